// File: doc/BRIEF.md
# Dual-Mode Converter Configuration Port

This block is the control front end of a data converter. A static strap input chooses how the converter is configured. With the strap low, three input pins (chip select, serial clock, serial data) and one open-drain data-out pin form a four-wire serial port. The port writes and reads a small bank of 8-bit mode registers. With the strap high, the same three input pins act directly as static controls. They set output randomization, front-end gain and output format. In both modes the block drives three decoded control bits and a high-impedance request for the converter's digital outputs.

All pins are brought into the block's system clock domain through a synchronizer chain. The serial clock is oversampled, and its rising edges are detected in that domain. A serial frame is 16 bits, sent MSB first: a read/write bit, a 7-bit register address, then 8 data bits. The frame is walked by a four-state machine:
- `ST_IDLE` is the state while chip select is high or the strap selects parallel mode.
- Chip select going low moves `ST_IDLE` to `ST_HDR`.
- The eighth rising clock edge moves `ST_HDR` to `ST_DATA`. The read/write bit and the address are latched here, and read data is loaded.
- The sixteenth rising edge moves `ST_DATA` to `ST_DONE` and commits a write.
- `ST_DONE` ignores further edges.
- Chip select going high, or the strap going high, returns any state to `ST_IDLE` at once. This discards an unfinished frame.

Top module: `cvt_cfg_port`

## Requirements
- R1: With `par_mode` low, the control outputs come from register fields. With `par_mode` high, they come from the pins. A control pin change reaches the outputs within 4 clock cycles.
- R2: In serial mode, while `cs_n_pin` is low, `sdat_pin` is captured on each rising edge of `sclk_pin`. Frame bit 15 is read/write (0 = write, 1 = read), bits 14:8 are the address and bits 7:0 are the data, sent MSB first. Register map, bit 0 of each: address 1 = gain select (1 = gain 1.5), address 2 = output format (1 = DDR LVDS), address 3 = randomization enable.
- R3: In a read frame, data bit k (MSB first, k = 0..7) is presented on data-out after rising edge 8+k. It is valid at the following falling edge of `sclk_pin`.
- R4: Data-out is open-drain. `sdo_pull_dn` = 1 pulls the line low; 0 releases it. The line is released when `cs_n_pin` is high and throughout a write frame.
- R5: If `cs_n_pin` rises before the sixteenth rising clock edge, the frame is discarded and no register changes.
- R6: After reset, all mode registers read 0. The outputs give gain 1, CMOS format and randomization off.
- R7: A write to address 0 with data bit 7 set clears every mode register. Address 0 always reads 0.
- R8: In parallel mode, `sdat_pin` drives `rand_en`, `sclk_pin` drives `gain_hi` (high = gain 1.5) and `cs_n_pin` drives `fmt_lvds` (high = DDR LVDS, low = full-rate CMOS).
- R9: In parallel mode, serial frames change no register and data-out stays released.
- R10: `dout_hiz` follows `shdn_pin` (1 = digital outputs high-impedance) within 4 clock cycles.
- R11: Writes to addresses at or above the register count are ignored, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | Static strap: 0 = serial port, 1 = parallel pins |
| shdn_pin | input | 1 | Shutdown request |
| cs_n_pin | input | 1 | Chip select (serial) / output format (parallel) |
| sclk_pin | input | 1 | Serial clock (serial) / gain select (parallel) |
| sdat_pin | input | 1 | Serial data in (serial) / randomization (parallel) |
| sdo_pull_dn | output | 1 | Open-drain pull-down enable for data-out |
| rand_en | output | 1 | Output randomization enable |
| gain_hi | output | 1 | Front-end gain: 0 = 1, 1 = 1.5 |
| fmt_lvds | output | 1 | Output format: 0 = full-rate CMOS, 1 = DDR LVDS |
| dout_hiz | output | 1 | Digital outputs to high impedance |

## Verification
Serial frames are tried three ways:
- Directed writes and reads of each field tell the three control bits apart.
- A long seeded random mix of reads, writes and early-aborted frames, over valid, reserved and out-of-range addresses, is checked against a bench model of the register bank.
- Reads check MSB-first ordering and falling-edge timing. Write frames are read back as an all-released data-out line.

Parallel mode is driven with random pin patterns that differ from the register contents, which shows which source feeds the outputs. Serial traffic sent during parallel mode is then shown to leave the bank unchanged.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } cfg_state_e;

    // Frame layout: 1 read/write bit + address forms one byte, then one data byte.
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int HDR_W  = 1 + ADDR_W;

    localparam logic [ADDR_W-1:0] A_RESET = 7'd0;
    localparam logic [ADDR_W-1:0] A_GAIN  = 7'd1;
    localparam logic [ADDR_W-1:0] A_FMT   = 7'd2;
    localparam logic [ADDR_W-1:0] A_RAND  = 7'd3;

    localparam int SOFT_RST_BIT = 7;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/cfg_serial_fsm.sv
module cfg_serial_fsm
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_en,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo_pull_dn,
    output cfg_state_e        state
);

    localparam int CNT_W    = $clog2(DATA_W + 1);
    localparam int HDR_LAST = HDR_W - 1;
    localparam int DAT_LAST = DATA_W - 1;

    cfg_state_e        nxt;
    logic              sclk_q;
    logic              rise;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] out_sh;
    logic [ADDR_W-1:0] addr_q;
    logic              is_read;
    logic              hdr_last;
    logic              dat_last;
    logic              leave;

    assign rise     = sclk_s & ~sclk_q;
    assign word     = {shreg[DATA_W-2:0], sdat_s};
    assign hdr_last = (cnt == CNT_W'(HDR_LAST));
    assign dat_last = (cnt == CNT_W'(DAT_LAST));
    assign leave    = ~serial_en | cs_n_s;

    // Next-state logic
    always_comb begin
        nxt = state;
        if (leave) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_HDR;
                ST_HDR:  if (rise && hdr_last) nxt = ST_DATA;
                ST_DATA: if (rise && dat_last) nxt = ST_DONE;
                ST_DONE: nxt = ST_DONE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Frame datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q      <= 1'b0;
            cnt         <= '0;
            shreg       <= '0;
            out_sh      <= '0;
            addr_q      <= '0;
            is_read     <= 1'b0;
            sdo_pull_dn <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            if (leave) begin
                cnt         <= '0;
                sdo_pull_dn <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        cnt         <= '0;
                        sdo_pull_dn <= 1'b0;
                    end
                    ST_HDR: begin
                        if (rise) begin
                            shreg <= word;
                            if (hdr_last) begin
                                cnt         <= '0;
                                is_read     <= word[DATA_W-1];
                                addr_q      <= word[ADDR_W-1:0];
                                out_sh      <= rd_data;
                                sdo_pull_dn <= word[DATA_W-1] & ~rd_data[DATA_W-1];
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (rise) begin
                            shreg  <= word;
                            cnt    <= cnt + 1'b1;
                            out_sh <= {out_sh[DATA_W-2:0], 1'b0};
                            if (!dat_last) begin
                                sdo_pull_dn <= is_read & ~out_sh[DATA_W-2];
                            end
                        end
                    end
                    ST_DONE: begin
                        cnt <= cnt;
                    end
                endcase
            end
        end
    end

    // Outputs toward the register bank
    always_comb begin
        rd_addr = word[ADDR_W-1:0];
        wr_addr = addr_q;
        wr_data = word;
        wr_en   = (state == ST_DATA) && rise && dat_last && !is_read && !leave;
    end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fld_gain,
    output logic              fld_fmt,
    output logic              fld_rand
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] bank [NUM_REGS];
    logic              soft_clr;

    assign soft_clr = wr_en && (wr_addr == A_RESET) && wr_data[SOFT_RST_BIT];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_ctl
            // Address 0 holds only the self-clearing reset bit.
            assign bank[0] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                     q <= '0;
                else if (soft_clr)                              q <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(i)))      q <= wr_data;
            end
            assign bank[i] = q;
        end
    end

    always_comb begin
        if (rd_addr < ADDR_W'(NUM_REGS)) rd_data = bank[rd_addr[IDX_W-1:0]];
        else                             rd_data = '0;
    end

    assign fld_gain = bank[A_GAIN[IDX_W-1:0]][0];
    assign fld_fmt  = bank[A_FMT[IDX_W-1:0]][0];
    assign fld_rand = bank[A_RAND[IDX_W-1:0]][0];

endmodule

// File: rtl/cvt_cfg_port.sv
module cvt_cfg_port
    import cfg_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic par_mode,
    input  logic shdn_pin,
    input  logic cs_n_pin,
    input  logic sclk_pin,
    input  logic sdat_pin,
    output logic sdo_pull_dn,
    output logic rand_en,
    output logic gain_hi,
    output logic fmt_lvds,
    output logic dout_hiz
);

    localparam int PIN_N   = 5;
    localparam int I_SDAT  = 0;
    localparam int I_SCLK  = 1;
    localparam int I_CS    = 2;
    localparam int I_SHDN  = 3;
    localparam int I_STRAP = 4;
    localparam logic [PIN_N-1:0] PIN_RST = PIN_N'(1) << I_CS;

    logic [PIN_N-1:0]  pins_s;
    logic              strap_s;
    logic              cs_n_s;
    cfg_state_e        fsm_state;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              fld_gain;
    logic              fld_fmt;
    logic              fld_rand;

    cfg_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({par_mode, shdn_pin, cs_n_pin, sclk_pin, sdat_pin}),
        .q     (pins_s)
    );

    assign strap_s = pins_s[I_STRAP];
    assign cs_n_s  = pins_s[I_CS];

    cfg_serial_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_en   (~strap_s),
        .cs_n_s      (cs_n_s),
        .sclk_s      (pins_s[I_SCLK]),
        .sdat_s      (pins_s[I_SDAT]),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sdo_pull_dn (sdo_pull_dn),
        .state       (fsm_state)
    );

    cfg_regbank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .fld_gain (fld_gain),
        .fld_fmt  (fld_fmt),
        .fld_rand (fld_rand)
    );

    // Control source selection
    always_comb begin
        if (strap_s) begin
            rand_en  = pins_s[I_SDAT];
            gain_hi  = pins_s[I_SCLK];
            fmt_lvds = cs_n_s;
        end else begin
            rand_en  = fld_rand;
            gain_hi  = fld_gain;
            fmt_lvds = fld_fmt;
        end
        dout_hiz = pins_s[I_SHDN];
    end

endmodule

// File: rtl/cfg_checker.sv
module cfg_checker
    import cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              strap_s,
    input logic              cs_n_s,
    input cfg_state_e        fsm_state,
    input logic              sdo_pull_dn,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              fld_gain,
    input logic              fld_fmt,
    input logic              fld_rand
);

    AST_PAR_SDO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        strap_s |=> !sdo_pull_dn); // R9

    AST_PAR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        strap_s |=> fsm_state == ST_IDLE); // R9

    AST_IDLE_SDO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_IDLE |-> !sdo_pull_dn); // R4

    AST_CS_HIGH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> fsm_state == ST_IDLE); // R5

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_RESET && wr_data[SOFT_RST_BIT])
        |=> (!fld_gain && !fld_fmt && !fld_rand)); // R7

    AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DATA && $past(fsm_state) != ST_DATA)
        |-> $past(fsm_state) == ST_HDR); // R2

endmodule

bind cvt_cfg_port cfg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_s     (strap_s),
    .cs_n_s      (cs_n_s),
    .fsm_state   (fsm_state),
    .sdo_pull_dn (sdo_pull_dn),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .fld_gain    (fld_gain),
    .fld_fmt     (fld_fmt),
    .fld_rand    (fld_rand)
);

// File: tb/tb_cvt_cfg_port.sv
module tb_cvt_cfg_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int NREG       = 4;
    localparam int SETTLE     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic par_mode = 1'b0;
    logic shdn_pin = 1'b0;
    logic cs_n_pin = 1'b1;
    logic sclk_pin = 1'b0;
    logic sdat_pin = 1'b0;
    logic sdo_pull_dn, rand_en, gain_hi, fmt_lvds, dout_hiz;
    logic sdo_line;

    int   n_chk = 0;
    int   n_fail = 0;
    logic [7:0] model [NREG];

    assign sdo_line = sdo_pull_dn ? 1'b0 : 1'b1;

    cvt_cfg_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .par_mode    (par_mode),
        .shdn_pin    (shdn_pin),
        .cs_n_pin    (cs_n_pin),
        .sclk_pin    (sclk_pin),
        .sdat_pin    (sdat_pin),
        .sdo_pull_dn (sdo_pull_dn),
        .rand_en     (rand_en),
        .gain_hi     (gain_hi),
        .fmt_lvds    (fmt_lvds),
        .dout_hiz    (dout_hiz)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [6:0] a);
        if (a >= 7'd1 && a < 7'(NREG)) return model[a[1:0]];
        return 8'h00;
    endfunction

    task automatic model_write(input logic [6:0] a, input logic [7:0] d);
        if (a == 7'd0) begin
            if (d[7]) for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        end else if (a < 7'(NREG)) begin
            model[a[1:0]] = d;
        end
    endtask

    // One frame; nbits < 16 aborts it. rd collects data-out at falling edges 8..15.
    task automatic frame(input logic rw, input logic [6:0] a, input logic [7:0] d,
                         input int nbits, output logic [7:0] rd);
        logic [15:0] w;
        w  = {rw, a, d};
        rd = 8'hFF;
        cs_n_pin = 1'b0;
        tick(SETTLE);
        for (int i = 0; i < nbits; i++) begin
            sdat_pin = w[15-i];
            tick(HALF_SCK);
            sclk_pin = 1'b1;
            tick(HALF_SCK);
            if (i >= 7 && i <= 14) rd[14-i] = sdo_line;
            sclk_pin = 1'b0;
        end
        tick(HALF_SCK);
        cs_n_pin = 1'b1;
        tick(6);
    endtask

    task automatic check_fields(input string req);
        check({req, " gain"}, 32'(gain_hi),  32'(model[1][0]));
        check({req, " fmt"},  32'(fmt_lvds), 32'(model[2][0]));
        check({req, " rand"}, 32'(rand_en),  32'(model[3][0]));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R6: reset state
        check_fields("R6 reset");
        check("R6 sdo released", 32'(sdo_pull_dn), 32'd0);
        check("R10 hiz off", 32'(dout_hiz), 32'd0);
        for (int a = 1; a < NREG; a++) begin
            frame(1'b1, 7'(a), 8'h00, 16, rd);
            check("R6 reset read", 32'(rd), 32'd0);
        end

        // R2/R3: directed field writes and MSB-first readback
        frame(1'b0, 7'd1, 8'h01, 16, rd); model_write(7'd1, 8'h01);
        check("R4 write frame sdo", 32'(rd), 32'hFF);
        check_fields("R2 gain");
        frame(1'b0, 7'd2, 8'hA5, 16, rd); model_write(7'd2, 8'hA5);
        check_fields("R2 fmt");
        frame(1'b1, 7'd2, 8'h00, 16, rd);
        check("R3 read A5", 32'(rd), 32'hA5);
        frame(1'b0, 7'd3, 8'h6B, 16, rd); model_write(7'd3, 8'h6B);
        check_fields("R2 rand");
        frame(1'b1, 7'd3, 8'h00, 16, rd);
        check("R3 read 6B", 32'(rd), 32'h6B);
        check("R4 released after cs", 32'(sdo_pull_dn), 32'd0);

        // R5: aborted frames
        frame(1'b0, 7'd1, 8'h00, 10, rd);
        frame(1'b0, 7'd1, 8'h00, 15, rd);
        check_fields("R5 abort");
        frame(1'b1, 7'd1, 8'h00, 16, rd);
        check("R5 abort readback", 32'(rd), 32'h01);

        // R11: out-of-range addresses
        frame(1'b0, 7'd9, 8'hFF, 16, rd);
        frame(1'b1, 7'd9, 8'h00, 16, rd);
        check("R11 read high addr", 32'(rd), 32'h00);
        frame(1'b1, 7'd127, 8'h00, 16, rd);
        check("R11 read top addr", 32'(rd), 32'h00);

        // R7: address 0 without and with bit 7
        frame(1'b0, 7'd0, 8'h7F, 16, rd); model_write(7'd0, 8'h7F);
        check_fields("R7 no clear");
        frame(1'b1, 7'd0, 8'h00, 16, rd);
        check("R7 addr0 reads 0", 32'(rd), 32'h00);
        frame(1'b0, 7'd0, 8'h80, 16, rd); model_write(7'd0, 8'h80);
        check_fields("R7 soft reset");
        frame(1'b1, 7'd2, 8'h00, 16, rd);
        check("R7 cleared read", 32'(rd), 32'h00);

        // R2/R3/R5: random mix against the model
        for (int n = 0; n < 80; n++) begin
            logic       rw;
            logic [6:0] a;
            logic [7:0] d;
            int         nb;
            rw = 1'($urandom_range(1, 0));
            a  = 7'($urandom_range(5, 0));
            d  = 8'($urandom);
            nb = ($urandom_range(7, 0) == 0) ? $urandom_range(15, 1) : 16;
            if (a == 7'd0 && $urandom_range(3, 0) != 0) d[7] = 1'b0;
            frame(rw, a, d, nb, rd);
            if (nb == 16) begin
                if (rw) check("R3 random read", 32'(rd), 32'(exp_read(a)));
                else begin
                    model_write(a, d);
                    check("R4 random write sdo", 32'(rd), 32'hFF);
                end
            end
            check_fields("R2 random fields");
        end

        // R10: shutdown
        shdn_pin = 1'b1; tick(SETTLE);
        check("R10 hiz on", 32'(dout_hiz), 32'd1);
        shdn_pin = 1'b0; tick(SETTLE);
        check("R10 hiz off again", 32'(dout_hiz), 32'd0);

        // R8/R1: parallel pins
        frame(1'b0, 7'd1, 8'h00, 16, rd); model_write(7'd1, 8'h00);
        frame(1'b0, 7'd2, 8'h01, 16, rd); model_write(7'd2, 8'h01);
        frame(1'b0, 7'd3, 8'h00, 16, rd); model_write(7'd3, 8'h00);
        par_mode = 1'b1;
        cs_n_pin = 1'b0; sclk_pin = 1'b1; sdat_pin = 1'b1;
        tick(SETTLE);
        check("R1 parallel gain", 32'(gain_hi), 32'd1);
        check("R1 parallel fmt", 32'(fmt_lvds), 32'd0);
        for (int n = 0; n < 30; n++) begin
            logic c, k, s;
            c = 1'($urandom_range(1, 0));
            k = 1'($urandom_range(1, 0));
            s = 1'($urandom_range(1, 0));
            cs_n_pin = c; sclk_pin = k; sdat_pin = s;
            tick(SETTLE);
            check("R8 rand pin", 32'(rand_en), 32'(s));
            check("R8 gain pin", 32'(gain_hi), 32'(k));
            check("R8 fmt pin", 32'(fmt_lvds), 32'(c));
            check("R9 sdo released", 32'(sdo_pull_dn), 32'd0);
        end
        cs_n_pin = 1'b1; sclk_pin = 1'b0; sdat_pin = 1'b0;
        tick(SETTLE);

        // R9: serial traffic during parallel mode
        frame(1'b0, 7'd3, 8'hFF, 16, rd);
        frame(1'b0, 7'd1, 8'hFF, 16, rd);
        frame(1'b1, 7'd2, 8'h00, 16, rd);
        check("R9 parallel read released", 32'(rd), 32'hFF);
        par_mode = 1'b0;
        tick(SETTLE);
        check_fields("R1 back to serial");
        frame(1'b1, 7'd3, 8'h00, 16, rd);
        check("R9 reg3 unchanged", 32'(rd), 32'(model[3]));
        frame(1'b1, 7'd1, 8'h00, 16, rd);
        check("R9 reg1 unchanged", 32'(rd), 32'(model[1]));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule